// File: doc/BRIEF.md
# Handshake-Chained Token FIFO

This block is a first-in-first-out buffer built as a chain of storage slots. Each slot talks only to its two neighbours through request and acknowledge lines, so it works like a micropipeline. Every slot owns one inverting C-element, kept in a register and sampled on a single system clock, and one data register. Flow control comes from the C-elements alone. A slot's request-out is also the acknowledge to the slot before it. The block has no read or write pointers and no counters.

Every handshake line uses two-phase signalling: each change of level, rising or falling, is one event.

On the input side, a producer places a word on `in_data` and toggles `in_req`. The word has been taken once `in_ack` equals `in_req`. On the output side, a word waits on `out_data` whenever `out_req` differs from `out_ack`. The consumer takes the word by toggling `out_ack`.

When the consumer stops, the slots fill from the tail backward until the head slot is blocked. Each readout shifts the contents forward by one place.

Top module: `mp_fifo`

## Requirements
- R1: While `rst_n` is low, every C-element output and every data register is zero. So `in_ack`=0, `out_req`=0, `out_data`=0, `head_busy`=0 and `tail_empty`=1.
- R2: Each slot's C-element takes the level of its incoming request on a clock edge where that request differs from the acknowledge from the next slot. Otherwise it holds. At the ports, `in_ack` takes the level of `in_req` on the first edge where `in_req`≠`in_ack` while `head_busy` is 0.
- R3: A loaded slot, whose request-out differs from the acknowledge of the slot after it, changes neither its request-out nor its data. An `in_req` event made while `head_busy` is 1 is not accepted until the head slot frees.
- R4: A slot's data register loads only on the edge where its request-out changes, and it then takes the data of the slot before it. `out_data` and `out_req` stay stable while `out_req`≠`out_ack`.
- R5: Words leave in the order they were accepted, with none lost and none repeated.
- R6: Take a word accepted into an empty chain, with `in_ack` changing at edge k. Its `out_req` event appears at edge k+DEPTH-1.
- R7: With no readout, exactly DEPTH words are accepted. After that `head_busy` is 1 and further input events are blocked.
- R8: Suppose the chain is full and a readout event arrives. The next word appears at the first clock edge after the readout. A pending input event is accepted DEPTH edges after the readout.
- R9: `tail_empty` is 1 exactly when `out_req`=`out_ack`. `head_busy` is 1 exactly when the head slot holds a word it has not yet passed on.
- R10: A change on `in_data` made without a new `in_req` event has no effect on any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all C-elements and data registers sample on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_req | input | 1 | Input request; each toggle offers one word |
| in_data | input | WIDTH | Word offered with the input request |
| in_ack | output | 1 | Input acknowledge; equals `in_req` once the word is taken |
| head_busy | output | 1 | Head slot is loaded and blocks new input events |
| out_req | output | 1 | Output request; differs from `out_ack` while a word waits |
| out_data | output | WIDTH | Word held by the tail slot |
| out_ack | input | 1 | Readout acknowledge; each toggle consumes one word |
| tail_empty | output | 1 | Tail slot holds no pending word |

## Verification
Some rules are checked on every cycle. A loaded slot never changes its request or data. Data changes only together with a request change. The head accepts a request one edge after it becomes acceptable and only when free. The waiting output word stays steady until it is read. Reset clears every slot.

Other rules need whole scenarios, and only the bench's scenarios show them. These are:
- ordering and completeness across a mixed stream;
- the exact DEPTH-1 edge latency through an empty chain;
- a capacity of exactly DEPTH words;
- the one-edge refill after a readout and the DEPTH-edge release of a blocked producer;
- that stray changes on the input data are not stored.

// File: rtl/mp_fifo_pkg.sv
package mp_fifo_pkg;

  // Next value of an inverting C-element: follows the non-inverting
  // input when the two inputs disagree, otherwise keeps its state.
  function automatic logic celem_next(input logic a_level,
                                      input logic b_level,
                                      input logic state);
    return (a_level != b_level) ? a_level : state;
  endfunction

  // Two-phase occupancy: a slot holds a word while its request-out
  // differs from the acknowledge returned by the slot after it.
  function automatic logic slot_loaded(input logic req_out,
                                       input logic ack_back);
    return req_out != ack_back;
  endfunction

endpackage

// File: rtl/mp_celement.sv
module mp_celement
  import mp_fifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_i,
  input  logic b_i,
  output logic q_o,
  output logic fire_o
);

  logic q_next;

  always_comb begin
    q_next = celem_next(a_i, b_i, q_o);
    fire_o = (q_next != q_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_next;
  end

endmodule

// File: rtl/mp_data_reg.sv
module mp_data_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

endmodule

// File: rtl/mp_stage.sv
module mp_stage
  import mp_fifo_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [WIDTH-1:0] data_o,
  output logic             fire_o,
  output logic             loaded_o
);

  mp_celement u_celem (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_i    (req_i),
    .b_i    (ack_i),
    .q_o    (req_o),
    .fire_o (fire_o)
  );

  // Data is captured on the same edge the request-out toggles, so the
  // word is already stable when the next slot sees the new request.
  mp_data_reg #(.WIDTH(WIDTH)) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (fire_o),
    .d_i    (data_i),
    .q_o    (data_o)
  );

  always_comb loaded_o = slot_loaded(req_o, ack_i);

endmodule

// File: rtl/mp_fifo.sv
module mp_fifo
  import mp_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_req,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ack,
  output logic             head_busy,
  output logic             out_req,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_ack,
  output logic             tail_empty
);

  localparam int LAST = DEPTH - 1;

  // req_chain[0] is the producer's request; req_chain[i+1] is the
  // request-out of slot i, which doubles as the acknowledge to slot i-1.
  logic [DEPTH:0]              req_chain;
  logic [DEPTH-1:0]            ack_chain;
  logic [DEPTH-1:0]            fire_vec;
  logic [DEPTH-1:0]            loaded_vec;
  logic [DEPTH-1:0][WIDTH-1:0] din_vec;
  logic [DEPTH-1:0][WIDTH-1:0] data_vec;

  assign req_chain[0] = in_req;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      if (gi == 0) begin : g_head_src
        assign din_vec[gi] = in_data;
      end else begin : g_mid_src
        assign din_vec[gi] = data_vec[gi-1];
      end

      if (gi == LAST) begin : g_tail_ack
        assign ack_chain[gi] = out_ack;
      end else begin : g_mid_ack
        assign ack_chain[gi] = req_chain[gi+2];
      end

      mp_stage #(.WIDTH(WIDTH)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_chain[gi]),
        .data_i   (din_vec[gi]),
        .ack_i    (ack_chain[gi]),
        .req_o    (req_chain[gi+1]),
        .data_o   (data_vec[gi]),
        .fire_o   (fire_vec[gi]),
        .loaded_o (loaded_vec[gi])
      );
    end
  endgenerate

  assign in_ack     = req_chain[1];
  assign head_busy  = loaded_vec[0];
  assign out_req    = req_chain[DEPTH];
  assign out_data   = data_vec[LAST];
  assign tail_empty = !loaded_vec[LAST];

endmodule

// File: rtl/mp_fifo_chk.sv
module mp_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_req,
  input logic                        in_ack,
  input logic                        head_busy,
  input logic                        out_req,
  input logic                        out_ack,
  input logic [WIDTH-1:0]            out_data,
  input logic [DEPTH-1:0]            slot_req,
  input logic [DEPTH-1:0]            slot_loaded,
  input logic [DEPTH-1:0][WIDTH-1:0] slot_data
);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (slot_req == '0 && slot_data == '0));

  a_r2_head_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req != in_ack && !head_busy) |=> (in_ack == $past(in_req)));

  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    head_busy |=> $stable(in_ack));

  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req != out_ack) |=> ($stable(out_req) && $stable(out_data)));

  genvar gs;
  generate
    for (gs = 0; gs < DEPTH; gs++) begin : g_slot_chk
      a_r3_loaded_holds: assert property (@(posedge clk) disable iff (!rst_n)
        slot_loaded[gs] |=> ($stable(slot_req[gs]) && $stable(slot_data[gs])));

      a_r4_data_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slot_data[gs]) |-> !$stable(slot_req[gs]));
    end
  endgenerate

endmodule

bind mp_fifo mp_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_req      (in_req),
  .in_ack      (in_ack),
  .head_busy   (head_busy),
  .out_req     (out_req),
  .out_ack     (out_ack),
  .out_data    (out_data),
  .slot_req    (req_chain[DEPTH:1]),
  .slot_loaded (loaded_vec),
  .slot_data   (data_vec)
);

// File: tb/test_mp_fifo.sv
`timescale 1ns/1ps
module test_mp_fifo;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_req = 1'b0;
  logic [WIDTH-1:0] in_data = '0;
  logic             in_ack;
  logic             head_busy;
  logic             out_req;
  logic [WIDTH-1:0] out_data;
  logic             out_ack = 1'b0;
  logic             tail_empty;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  mp_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_mp_fifo (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
    .in_ack(in_ack), .head_busy(head_busy), .out_req(out_req),
    .out_data(out_data), .out_ack(out_ack), .tail_empty(tail_empty)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  function automatic int gap();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr[1:0]);
  endfunction

  // Offer one word and wait until the head takes it.
  task automatic put(input logic [WIDTH-1:0] d);
    @(negedge clk);
    in_data = d;
    in_req  = ~in_req;
    do @(negedge clk); while (in_ack !== in_req);
  endtask

  // Wait for a waiting word, check it, consume it.
  task automatic take(input logic [WIDTH-1:0] exp, input string tag);
    while (out_req === out_ack) @(negedge clk);
    check({tag, " R5 order"}, out_data, exp);
    check("R9 tail_empty low while word waits", tail_empty, 1'b0);
    out_ack = ~out_ack;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in_ack", in_ack, 1'b0);
    check("R1 out_req", out_req, 1'b0);
    check("R1 out_data", out_data, '0);
    check("R1 head_busy", head_busy, 1'b0);
    check("R1 tail_empty", tail_empty, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_latency();
    int n;
    @(negedge clk);
    in_data = 8'hA5;
    in_req  = ~in_req;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        check("R2 in_ack follows in_req", in_ack, in_req);
        in_data = 8'h3C;            // R10: stray data change, no event
      end
      if (n == 3) in_data = 8'hC3;
    end while (out_req === out_ack && n < 4 * DEPTH);
    check("R6 empty-chain latency", n, DEPTH);
    check("R4/R10 word kept", out_data, 8'hA5);
    check("R9 tail_empty with word", tail_empty, 1'b0);
    out_ack = ~out_ack;
    @(negedge clk);
    check("R9 tail_empty after readout", tail_empty, 1'b1);
    check("R9 out_req equals out_ack", out_req, out_ack);
  endtask

  task automatic t_fill_and_release();
    int n;
    logic [7:0] held;
    for (int i = 0; i < DEPTH; i++) put(8'h10 + 8'(i));
    repeat (DEPTH) @(negedge clk);
    check("R7 head_busy after DEPTH words", head_busy, 1'b1);
    // Extra event while full must stay pending.
    in_data = 8'hEE;
    in_req  = ~in_req;
    held    = out_data;
    repeat (6) @(negedge clk);
    check("R3 blocked event not acknowledged", in_ack != in_req, 1'b1);
    check("R4 out_data stable while waiting", out_data, held);
    check("R5 first word at tail", out_data, 8'h10);
    out_ack = ~out_ack;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        check("R8 next word after one edge", out_req != out_ack, 1'b1);
        check("R8 next word value", out_data, 8'h11);
      end
    end while (in_ack !== in_req && n < 4 * DEPTH);
    check("R8 blocked producer released", n, DEPTH);
    for (int i = 1; i < DEPTH; i++) take(8'h10 + 8'(i), "drain");
    take(8'hEE, "drain extra");
    check("R9 tail_empty when drained", tail_empty, 1'b1);
    check("R9 head_busy when drained", head_busy, 1'b0);
  endtask

  task automatic t_stream();
    localparam int N = 48;
    fork
      begin
        for (int i = 0; i < N; i++) begin
          repeat (gap()) @(negedge clk);
          put(8'h40 + 8'(i));
        end
      end
      begin
        for (int i = 0; i < N; i++) begin
          repeat (gap()) @(negedge clk);
          take(8'h40 + 8'(i), "stream");
        end
      end
    join
    check("R5 stream fully drained", tail_empty, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_fill_and_release();
    t_stream();
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule